// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Detection

This block recovers characters from an asynchronous serial line. It is driven by an oversampling tick: one enable pulse per sample, normally sixteen per bit period, or eight in the fast-sampling mode. The line first passes through a synchroniser. A falling edge then starts a frame. Each bit is decided by a three-sample majority vote taken around the bit's centre, which screens out short spikes. A start bit that no longer reads low at its centre is dropped as a false start.

After the start bit come 5 to 9 data bits, least significant first. An optional parity bit follows, and then the stop bit. Once the stop bit has been judged, the character and its parity and framing status go into a holding register. A ready flag is raised, and it stays up until the consumer pulses the read strobe. If another frame completes before that read, the overrun flag is set and the new frame is lost. In multi-drop mode, frames whose ninth bit is 0 are discarded, so a station only sees address frames until software leaves that mode.

Top module: `serial_rx_core`

## Requirements
- R1: With `cfg_data_bits` set to 5, 6, 7, 8 or 9, that many data bits are received least significant bit first. They appear in `rd_data[cfg_data_bits-1:0]`, and the bits of `rd_data` above that width read 0.
- R2: Each bit is the majority of three consecutive samples at the bit centre: samples 7, 8 and 9 of 0..15 in normal mode, and samples 3, 4 and 5 of 0..7 in fast mode. A single inverted sample inside a bit does not change the received value.
- R3: A start bit whose majority vote at its centre is 1 is a false start. It produces no character, and the receiver goes back to waiting for a falling edge.
- R4: When `cfg_parity_en` is 1, a parity bit follows the data. With `cfg_parity_odd`=0 the data bits plus the parity bit must hold an even number of ones, and with `cfg_parity_odd`=1 an odd number. A mismatch sets `err_parity` together with that character. With parity disabled, `err_parity` is 0.
- R5: `err_frame` is set together with a character whose first stop bit is voted 0. Only the first stop bit is examined.
- R6: When a completed frame is stored, `rx_ready` becomes 1 and stays 1 until it is read.
- R7: If a frame completes while `rx_ready` is 1 and no read is taking place, `err_overrun` becomes 1. The held character and its flags stay unchanged.
- R8: A one-cycle pulse on `rd_strobe` clears `rx_ready` and `err_overrun` in the following cycle.
- R9: With `cfg_fast` set to 1, a bit lasts 8 ticks instead of 16, and reception is otherwise the same.
- R10: With `cfg_multidrop` set to 1, a frame whose data bit 8 is 0 is discarded and changes no output. A frame whose data bit 8 is 1 is stored normally.
- R11: After reset, `rx_ready`, `err_overrun`, `err_frame`, `err_parity` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Oversampling tick, one pulse per sample |
| rx_line | input | 1 | Serial receive line, idle high |
| cfg_data_bits | input | 4 | Data bits per frame, 5 to 9 |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_fast | input | 1 | 8 samples per bit instead of 16 |
| cfg_multidrop | input | 1 | Discard frames whose data bit 8 is 0 |
| rd_strobe | input | 1 | Consumer read pulse |
| rd_data | output | 9 | Held character |
| rx_ready | output | 1 | Unread character available |
| err_frame | output | 1 | Stop bit of the held character read 0 |
| err_parity | output | 1 | Parity mismatch on the held character |
| err_overrun | output | 1 | A frame was lost while a character was unread |

## Verification
The line passes through two synchroniser stages, and each frame is then judged at the centre of its first stop bit. The stored result therefore appears about a dozen ticks into the stop bit: sample 9 plus the synchroniser and register delays, or sample 5 and the same delays in fast mode. The bench drives one tick per clock, holds the line high for several bit periods after each stop bit, and only then samples the outputs. This keeps every sample clear of the update point in both sampling modes. Read-strobe effects are due one cycle after the pulse, and the bench checks them at the falling edge after that cycle.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DATA_MAX = 9;
  localparam int DATA_MIN = 5;

  typedef enum logic [2:0] {
    RX_HUNT   = 3'd0,
    RX_START  = 3'd1,
    RX_DATA   = 3'd2,
    RX_PARITY = 3'd3,
    RX_STOP   = 3'd4
  } rx_state_t;
endpackage

// File: rtl/rx_line_filter.sv
module rx_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic rx_line,
  output logic line_s,
  output logic vote
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             win_q;
  logic [1:0]             win_d;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= rx_line;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b1;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign line_s = sync_q[SYNC_STAGES-1];

  // majority of two stored samples and the current one
  assign vote = (win_q[1] & win_q[0]) | (win_q[1] & line_s) | (win_q[0] & line_s);

  always_comb begin
    win_d = win_q;
    if (tick_en) win_d = {win_q[0], line_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 2'b11;
    else        win_q <= win_d;
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OS_NORMAL = 16,
  parameter int OS_FAST   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                line_s,
  input  logic                vote,
  input  logic [3:0]          cfg_data_bits,
  input  logic                cfg_parity_en,
  input  logic                cfg_parity_odd,
  input  logic                cfg_fast,
  output logic                frame_done,
  output logic [DATA_MAX-1:0] frame_data,
  output logic                frame_perr,
  output logic                frame_ferr
);
  localparam int CNT_W = $clog2(OS_NORMAL);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(OS_NORMAL - 1);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(OS_FAST - 1);
  localparam logic [CNT_W-1:0] MID_N  = CNT_W'(OS_NORMAL / 2 + 1);
  localparam logic [CNT_W-1:0] MID_F  = CNT_W'(OS_FAST / 2 + 1);

  rx_state_t           state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [3:0]          idx_q, idx_d;
  logic [DATA_MAX-1:0] data_q, data_d;
  logic                perr_q, perr_d;
  logic                done_d, ferr_d;

  logic [CNT_W-1:0]    last_c, mid_c;
  logic [3:0]          eff_bits;
  logic                at_mid, at_last, par_exp;

  always_comb begin
    if (cfg_data_bits < 4'(DATA_MIN))      eff_bits = 4'(DATA_MIN);
    else if (cfg_data_bits > 4'(DATA_MAX)) eff_bits = 4'(DATA_MAX);
    else                                   eff_bits = cfg_data_bits;
  end

  assign last_c  = cfg_fast ? LAST_F : LAST_N;
  assign mid_c   = cfg_fast ? MID_F  : MID_N;
  assign at_mid  = (cnt_q == mid_c);
  assign at_last = (cnt_q == last_c);
  assign par_exp = (^data_q) ^ cfg_parity_odd;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    data_d  = data_q;
    perr_d  = perr_q;
    done_d  = 1'b0;
    ferr_d  = 1'b0;
    if (tick_en) begin
      if (state_q == RX_HUNT) begin
        if (!line_s) begin
          state_d = RX_START;
          cnt_d   = CNT_W'(1);
          idx_d   = 4'd0;
          data_d  = '0;
          perr_d  = 1'b0;
        end
      end else begin
        cnt_d = at_last ? '0 : cnt_q + CNT_W'(1);
        unique case (state_q)
          RX_START: begin
            if (at_mid && vote) state_d = RX_HUNT;
            else if (at_last)   state_d = RX_DATA;
          end
          RX_DATA: begin
            if (at_mid) data_d[idx_q] = vote;
            if (at_last) begin
              if (idx_q == eff_bits - 4'd1) begin
                idx_d   = 4'd0;
                state_d = cfg_parity_en ? RX_PARITY : RX_STOP;
              end else begin
                idx_d = idx_q + 4'd1;
              end
            end
          end
          RX_PARITY: begin
            if (at_mid)  perr_d  = (vote != par_exp);
            if (at_last) state_d = RX_STOP;
          end
          RX_STOP: begin
            if (at_mid) begin
              done_d  = 1'b1;
              ferr_d  = ~vote;
              state_d = RX_HUNT;
            end
          end
          default: state_d = RX_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
    end
  end

  assign frame_done = done_d;
  assign frame_data = data_q;
  assign frame_perr = perr_q;
  assign frame_ferr = ferr_d;
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
  import serial_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_done,
  input  logic [DATA_MAX-1:0] frame_data,
  input  logic                frame_perr,
  input  logic                frame_ferr,
  input  logic                cfg_multidrop,
  input  logic                rd_strobe,
  output logic                accept,
  output logic [DATA_MAX-1:0] rd_data,
  output logic                rx_ready,
  output logic                err_frame,
  output logic                err_parity,
  output logic                err_overrun
);
  logic [DATA_MAX-1:0] data_q, data_d;
  logic                rdy_q, rdy_d, fe_q, fe_d, pe_q, pe_d, ov_q, ov_d;

  assign accept = frame_done & (~cfg_multidrop | frame_data[DATA_MAX-1]);

  always_comb begin
    data_d = data_q;
    rdy_d  = rdy_q;
    fe_d   = fe_q;
    pe_d   = pe_q;
    ov_d   = ov_q;
    if (accept) begin
      if (rdy_q && !rd_strobe) begin
        ov_d = 1'b1;
      end else begin
        data_d = frame_data;
        fe_d   = frame_ferr;
        pe_d   = frame_perr;
        rdy_d  = 1'b1;
        ov_d   = 1'b0;
      end
    end else if (rd_strobe) begin
      rdy_d = 1'b0;
      ov_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      rdy_q  <= rdy_d;
      fe_q   <= fe_d;
      pe_q   <= pe_d;
      ov_q   <= ov_d;
    end
  end

  assign rd_data     = data_q;
  assign rx_ready    = rdy_q;
  assign err_frame   = fe_q;
  assign err_parity  = pe_q;
  assign err_overrun = ov_q;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OS_NORMAL   = 16,
  parameter int OS_FAST     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       rx_line,
  input  logic [3:0] cfg_data_bits,
  input  logic       cfg_parity_en,
  input  logic       cfg_parity_odd,
  input  logic       cfg_fast,
  input  logic       cfg_multidrop,
  input  logic       rd_strobe,
  output logic [8:0] rd_data,
  output logic       rx_ready,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun
);
  logic [1:0]          rst_sync_q;
  logic                rst_core_n;
  logic                line_s, vote;
  logic                frame_done, frame_perr, frame_ferr, frame_accept;
  logic [DATA_MAX-1:0] frame_data;

  // asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  rx_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick_en (tick_en),
    .rx_line (rx_line),
    .line_s  (line_s),
    .vote    (vote)
  );

  rx_frame_fsm #(.OS_NORMAL(OS_NORMAL), .OS_FAST(OS_FAST)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_core_n),
    .tick_en        (tick_en),
    .line_s         (line_s),
    .vote           (vote),
    .cfg_data_bits  (cfg_data_bits),
    .cfg_parity_en  (cfg_parity_en),
    .cfg_parity_odd (cfg_parity_odd),
    .cfg_fast       (cfg_fast),
    .frame_done     (frame_done),
    .frame_data     (frame_data),
    .frame_perr     (frame_perr),
    .frame_ferr     (frame_ferr)
  );

  rx_hold_reg u_hold (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .frame_done    (frame_done),
    .frame_data    (frame_data),
    .frame_perr    (frame_perr),
    .frame_ferr    (frame_ferr),
    .cfg_multidrop (cfg_multidrop),
    .rd_strobe     (rd_strobe),
    .accept        (frame_accept),
    .rd_data       (rd_data),
    .rx_ready      (rx_ready),
    .err_frame     (err_frame),
    .err_parity    (err_parity),
    .err_overrun   (err_overrun)
  );
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       rd_strobe,
  input logic [3:0] cfg_data_bits,
  input logic       cfg_multidrop,
  input logic [8:0] rd_data,
  input logic       rx_ready,
  input logic       err_overrun
);
  // R6
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !rx_ready |=> rx_ready);

  // R7
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && rx_ready && !rd_strobe |=> err_overrun && $stable(rd_data));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !accept |=> !rx_ready && !err_overrun);

  // R7
  overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> rx_ready);

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && $stable(cfg_data_bits) && cfg_data_bits >= 4'd5 && cfg_data_bits <= 4'd9
      |-> (rd_data >> cfg_data_bits) == 9'd0);

  // R10
  multidrop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_multidrop && accept && !rx_ready |=> rd_data[8]);
endmodule

bind serial_rx_core serial_rx_core_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .accept        (frame_accept),
  .rd_strobe     (rd_strobe),
  .cfg_data_bits (cfg_data_bits),
  .cfg_multidrop (cfg_multidrop),
  .rd_data       (rd_data),
  .rx_ready      (rx_ready),
  .err_overrun   (err_overrun)
);

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       rx_line = 1'b1;
  logic [3:0] cfg_data_bits = 4'd8;
  logic       cfg_parity_en = 1'b0;
  logic       cfg_parity_odd = 1'b0;
  logic       cfg_fast = 1'b0;
  logic       cfg_multidrop = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [8:0] rd_data;
  logic       rx_ready, err_frame, err_parity, err_overrun;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  serial_rx_core uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_line(rx_line),
    .cfg_data_bits(cfg_data_bits), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd), .cfg_fast(cfg_fast),
    .cfg_multidrop(cfg_multidrop), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .rx_ready(rx_ready), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    rx_line = 1'b1;
    for (int i = 0; i < n; i++) step();
  endtask

  // glitch_bit: position within frame (0 = start) receiving one bad sample at sample 8
  task automatic send(input logic [8:0] val, input int nbits, input bit par_en,
                      input bit odd, input bit bad_par, input bit stop_v,
                      input int glitch_bit);
    int n;
    logic [9:0] bits;
    int total;
    logic par;
    n = cfg_fast ? 8 : 16;
    par = odd;
    for (int i = 0; i < nbits; i++) par ^= val[i];
    if (bad_par) par = ~par;
    total = 0;
    bits[0] = 1'b0;
    for (int i = 0; i < nbits; i++) bits[i+1] = val[i];
    total = nbits + 1;
    for (int b = 0; b < total + (par_en ? 1 : 0) + 1; b++) begin
      logic v;
      if (b < total)                   v = bits[b];
      else if (par_en && b == total)   v = par;
      else                             v = stop_v;
      for (int c = 0; c < n; c++) begin
        rx_line = (b == glitch_bit && c == (n / 2)) ? ~v : v;
        step();
      end
    end
    idle(3 * n);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    step();
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 ready", rx_ready, 0);
    check("R11 data", rd_data, 0);
    check("R11 flags", {err_frame, err_parity, err_overrun}, 0);
  endtask

  task automatic t_basic();
    cfg_data_bits = 4'd8;
    send(9'h0A5, 8, 0, 0, 0, 1, -1);
    @(negedge clk);
    check("R6 ready", rx_ready, 1);
    check("R1 8-bit data", rd_data, 9'h0A5);
    check("R4 no parity err", err_parity, 0);
    check("R5 no frame err", err_frame, 0);
    do_read();
    check("R8 ready cleared", rx_ready, 0);
  endtask

  task automatic t_widths();
    cfg_data_bits = 4'd5;
    send(9'h1F5, 5, 0, 0, 0, 1, -1);
    @(negedge clk);
    check("R1 5-bit data", rd_data, 9'h015);
    do_read();
    cfg_data_bits = 4'd9;
    send(9'h1A3, 9, 0, 0, 0, 1, -1);
    @(negedge clk);
    check("R1 9-bit data", rd_data, 9'h1A3);
    do_read();
    cfg_data_bits = 4'd8;
  endtask

  task automatic t_parity();
    cfg_parity_en = 1'b1;
    cfg_parity_odd = 1'b0;
    send(9'h0A5, 8, 1, 0, 0, 1, -1);
    @(negedge clk);
    check("R4 even ok", {rx_ready, err_parity}, 2'b10);
    do_read();
    send(9'h0A5, 8, 1, 0, 1, 1, -1);
    @(negedge clk);
    check("R4 even bad", {rx_ready, err_parity}, 2'b11);
    check("R4 data kept", rd_data, 9'h0A5);
    do_read();
    cfg_parity_odd = 1'b1;
    send(9'h007, 8, 1, 1, 0, 1, -1);
    @(negedge clk);
    check("R4 odd ok", {rx_ready, err_parity}, 2'b10);
    do_read();
    send(9'h007, 8, 1, 1, 1, 1, -1);
    @(negedge clk);
    check("R4 odd bad", err_parity, 1);
    do_read();
    cfg_parity_en = 1'b0;
    cfg_parity_odd = 1'b0;
  endtask

  task automatic t_frame();
    send(9'h03C, 8, 0, 0, 0, 0, -1);
    idle(40);
    @(negedge clk);
    check("R5 frame err", {rx_ready, err_frame}, 2'b11);
    check("R5 data", rd_data, 9'h03C);
    do_read();
    check("R5 nothing extra", rx_ready, 0);
  endtask

  task automatic t_overrun();
    send(9'h011, 8, 0, 0, 0, 1, -1);
    send(9'h022, 8, 0, 0, 0, 1, -1);
    @(negedge clk);
    check("R7 overrun", {rx_ready, err_overrun}, 2'b11);
    check("R7 old data held", rd_data, 9'h011);
    do_read();
    check("R8 clears overrun", {rx_ready, err_overrun}, 2'b00);
  endtask

  task automatic t_false_start();
    rx_line = 1'b0;
    for (int i = 0; i < 4; i++) step();
    idle(60);
    @(negedge clk);
    check("R3 false start ignored", rx_ready, 0);
    send(9'h05B, 8, 0, 0, 0, 1, -1);
    @(negedge clk);
    check("R3 next frame clean", rd_data, 9'h05B);
    do_read();
  endtask

  task automatic t_glitch();
    send(9'h0FF, 8, 0, 0, 0, 1, 3);
    @(negedge clk);
    check("R2 glitch on data", rd_data, 9'h0FF);
    do_read();
    send(9'h000, 8, 0, 0, 0, 1, 5);
    @(negedge clk);
    check("R2 glitch on zero bit", rd_data, 9'h000);
    check("R2 frame delivered", rx_ready, 1);
    do_read();
  endtask

  task automatic t_fast();
    cfg_fast = 1'b1;
    send(9'h05A, 8, 0, 0, 0, 1, -1);
    @(negedge clk);
    check("R9 fast data", {rx_ready, rd_data}, {1'b1, 9'h05A});
    do_read();
    cfg_fast = 1'b0;
  endtask

  task automatic t_multidrop();
    cfg_multidrop = 1'b1;
    cfg_data_bits = 4'd9;
    send(9'h055, 9, 0, 0, 0, 1, -1);
    @(negedge clk);
    check("R10 data frame dropped", {rx_ready, rd_data}, {1'b0, 9'h05A});
    send(9'h1C4, 9, 0, 0, 0, 1, -1);
    @(negedge clk);
    check("R10 address frame", {rx_ready, rd_data}, {1'b1, 9'h1C4});
    do_read();
    cfg_multidrop = 1'b0;
    cfg_data_bits = 4'd8;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(8);
    t_reset();
    t_basic();
    t_widths();
    t_parity();
    t_frame();
    t_overrun();
    t_false_start();
    t_glitch();
    t_fast();
    t_multidrop();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule